// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block is the bypass network of a five-stage integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It compares the source register numbers of the instruction now in execute against the destination numbers held in the two later pipeline registers. For each ALU operand it picks the newest in-flight copy of the value and reports which copy it picked as a 2-bit select code. With this, a chain of up to three dependent instructions after a producer runs without waiting for writeback.

Two more paths finish the job. The first serves a store in the memory stage. Its write-data value is replaced by the writeback-stage result when the store's data register matches that destination, so a store right behind a dependent ALU operation needs no extra stall. The second serves the decode-stage register read. When decode reads a register in the same cycle that writeback writes it, a bypass returns the value being written. A parameter can drop this bypass for a register file that is already write-first.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory register writes (exm_wen=1) a nonzero destination equal to an ALU source number, that operand equals exm_result and its select reads 2'b10.
- R2: When only the memory/writeback register writes (mwb_wen=1) a nonzero destination equal to an ALU source number, that operand equals mwb_result and its select reads 2'b01.
- R3: When both producers match the same source, the execute/memory result wins (select 2'b10), because it is the younger one.
- R4: With no qualifying match, the operand is the value read from the register file and its select reads 2'b00.
- R5: Source register 0 is never forwarded. Its operand is always the register-file value, with select 2'b00, whatever the producers hold.
- R6: A producer whose write enable is low never supplies a forwarded value, even if its destination number matches.
- R7: The store write data equals mwb_result and st_fwd=1 when the memory-stage store data register is nonzero and equals a writing memory/writeback destination. Otherwise it equals mem_st_val and st_fwd=0.
- R8: With WB_BYPASS=1, a decode-stage read of a nonzero register that writeback is writing this cycle returns mwb_result. Any other read returns the register-file value unchanged.
- R9: The two ALU operands are resolved independently. Each can take a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | REG_BITS | First source register number of the execute-stage instruction |
| ex_rs2 | input | REG_BITS | Second source register number of the execute-stage instruction |
| ex_rf1 | input | XLEN | First operand as read from the register file |
| ex_rf2 | input | XLEN | Second operand as read from the register file |
| exm_rd | input | REG_BITS | Destination held in the execute/memory register |
| exm_wen | input | 1 | Register-write enable of the execute/memory instruction |
| exm_result | input | XLEN | ALU result held in the execute/memory register |
| mwb_rd | input | REG_BITS | Destination held in the memory/writeback register |
| mwb_wen | input | 1 | Register-write enable of the memory/writeback instruction |
| mwb_result | input | XLEN | Result held in the memory/writeback register |
| mem_st_rs | input | REG_BITS | Store data register number of the memory-stage instruction |
| mem_st_val | input | XLEN | Store data carried down from execute |
| id_rs1 | input | REG_BITS | First decode-stage read register number |
| id_rs2 | input | REG_BITS | Second decode-stage read register number |
| id_rf1 | input | XLEN | First decode-stage register-file read value |
| id_rf2 | input | XLEN | Second decode-stage register-file read value |
| alu_a | output | XLEN | Forwarded first ALU operand |
| alu_b | output | XLEN | Forwarded second ALU operand |
| sel_a | output | 2 | Source code of alu_a (00 file, 01 writeback, 10 execute/memory) |
| sel_b | output | 2 | Source code of alu_b |
| st_data | output | XLEN | Write data for data memory |
| st_fwd | output | 1 | High when st_data came from the writeback result |
| id_op1 | output | XLEN | First decode-stage operand after the writeback bypass |
| id_op2 | output | XLEN | Second decode-stage operand after the writeback bypass |

## Verification
A directed dependent chain models a producer followed by three readers. It shows that each of the three distance cases (execute/memory, memory/writeback, same-cycle writeback read) picks the correct path, and a following store shows that store data is taken from writeback. Further corner vectors put one destination in both producers, clear the write enables, and aim a producer at register 0. These separate the priority rule from the qualifying conditions. Random vectors draw register numbers from a small range so that matches are frequent. With the two operands drawn independently, they expose any mix-up between the two operands or any leakage between paths.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   // Operand source codes; downstream mux decoding depends on these values
   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_EXM = 2'b10
   } src_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
   parameter int REG_BITS = 5
) (
   input  logic [REG_BITS-1:0] reader_idx,
   input  logic [REG_BITS-1:0] writer_idx,
   input  logic                writer_en,
   output logic                hit
);
   localparam logic [REG_BITS-1:0] ZERO_REG = '0;

   always_comb begin
      hit = writer_en && (writer_idx == reader_idx) && (reader_idx != ZERO_REG);
   end
endmodule

// File: rtl/fwd_single.sv
module fwd_single #(
   parameter int XLEN     = 32,
   parameter int REG_BITS = 5
) (
   input  logic [REG_BITS-1:0] reader_idx,
   input  logic [XLEN-1:0]     base_val,
   input  logic [REG_BITS-1:0] writer_idx,
   input  logic                writer_en,
   input  logic [XLEN-1:0]     writer_val,
   output logic                taken,
   output logic [XLEN-1:0]     out_val
);
   fwd_hit #(.REG_BITS(REG_BITS)) u_hit (
      .reader_idx (reader_idx),
      .writer_idx (writer_idx),
      .writer_en  (writer_en),
      .hit        (taken)
   );

   always_comb begin
      out_val = taken ? writer_val : base_val;
   end
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
   import fwd_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int REG_BITS = 5
) (
   input  logic [REG_BITS-1:0] src_idx,
   input  logic [XLEN-1:0]     rf_val,
   input  logic [REG_BITS-1:0] exm_idx,
   input  logic                exm_en,
   input  logic [XLEN-1:0]     exm_val,
   input  logic [REG_BITS-1:0] mwb_idx,
   input  logic                mwb_en,
   input  logic [XLEN-1:0]     mwb_val,
   output logic [1:0]          sel,
   output logic [XLEN-1:0]     val
);
   logic hit_exm;
   logic hit_mwb;
   src_sel_e code;

   fwd_hit #(.REG_BITS(REG_BITS)) u_exm (
      .reader_idx (src_idx),
      .writer_idx (exm_idx),
      .writer_en  (exm_en),
      .hit        (hit_exm)
   );

   fwd_hit #(.REG_BITS(REG_BITS)) u_mwb (
      .reader_idx (src_idx),
      .writer_idx (mwb_idx),
      .writer_en  (mwb_en),
      .hit        (hit_mwb)
   );

   // Younger producer first
   always_comb begin
      if (hit_exm)      code = SRC_EXM;
      else if (hit_mwb) code = SRC_WB;
      else              code = SRC_RF;
   end

   always_comb begin
      unique case (code)
         SRC_EXM: val = exm_val;
         SRC_WB:  val = mwb_val;
         default: val = rf_val;
      endcase
      sel = code;
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
   parameter int XLEN      = 32,
   parameter int REG_BITS  = 5,
   parameter bit WB_BYPASS = 1'b1
) (
   input  logic [REG_BITS-1:0] ex_rs1,
   input  logic [REG_BITS-1:0] ex_rs2,
   input  logic [XLEN-1:0]     ex_rf1,
   input  logic [XLEN-1:0]     ex_rf2,
   input  logic [REG_BITS-1:0] exm_rd,
   input  logic                exm_wen,
   input  logic [XLEN-1:0]     exm_result,
   input  logic [REG_BITS-1:0] mwb_rd,
   input  logic                mwb_wen,
   input  logic [XLEN-1:0]     mwb_result,
   input  logic [REG_BITS-1:0] mem_st_rs,
   input  logic [XLEN-1:0]     mem_st_val,
   input  logic [REG_BITS-1:0] id_rs1,
   input  logic [REG_BITS-1:0] id_rs2,
   input  logic [XLEN-1:0]     id_rf1,
   input  logic [XLEN-1:0]     id_rf2,
   output logic [XLEN-1:0]     alu_a,
   output logic [XLEN-1:0]     alu_b,
   output logic [1:0]          sel_a,
   output logic [1:0]          sel_b,
   output logic [XLEN-1:0]     st_data,
   output logic                st_fwd,
   output logic [XLEN-1:0]     id_op1,
   output logic [XLEN-1:0]     id_op2
);
   localparam int N_ALU_SRC = 2;
   localparam int N_ID_SRC  = 2;

   if (XLEN < 1) begin : g_bad_xlen
      $error("fwd_unit: XLEN must be at least 1");
   end
   if (REG_BITS < 1) begin : g_bad_regbits
      $error("fwd_unit: REG_BITS must be at least 1");
   end

   logic [REG_BITS-1:0] alu_idx [N_ALU_SRC];
   logic [XLEN-1:0]     alu_rf  [N_ALU_SRC];
   logic [XLEN-1:0]     alu_val [N_ALU_SRC];
   logic [1:0]          alu_sel [N_ALU_SRC];

   assign alu_idx[0] = ex_rs1;
   assign alu_idx[1] = ex_rs2;
   assign alu_rf[0]  = ex_rf1;
   assign alu_rf[1]  = ex_rf2;

   for (genvar i = 0; i < N_ALU_SRC; i++) begin : g_alu
      fwd_operand #(.XLEN(XLEN), .REG_BITS(REG_BITS)) u_op (
         .src_idx (alu_idx[i]),
         .rf_val  (alu_rf[i]),
         .exm_idx (exm_rd),
         .exm_en  (exm_wen),
         .exm_val (exm_result),
         .mwb_idx (mwb_rd),
         .mwb_en  (mwb_wen),
         .mwb_val (mwb_result),
         .sel     (alu_sel[i]),
         .val     (alu_val[i])
      );
   end

   assign alu_a = alu_val[0];
   assign alu_b = alu_val[1];
   assign sel_a = alu_sel[0];
   assign sel_b = alu_sel[1];

   // Store data taken from the writeback result
   fwd_single #(.XLEN(XLEN), .REG_BITS(REG_BITS)) u_store (
      .reader_idx (mem_st_rs),
      .base_val   (mem_st_val),
      .writer_idx (mwb_rd),
      .writer_en  (mwb_wen),
      .writer_val (mwb_result),
      .taken      (st_fwd),
      .out_val    (st_data)
   );

   logic [REG_BITS-1:0] rd_idx [N_ID_SRC];
   logic [XLEN-1:0]     rd_rf  [N_ID_SRC];
   logic [XLEN-1:0]     rd_out [N_ID_SRC];

   assign rd_idx[0] = id_rs1;
   assign rd_idx[1] = id_rs2;
   assign rd_rf[0]  = id_rf1;
   assign rd_rf[1]  = id_rf2;

   for (genvar j = 0; j < N_ID_SRC; j++) begin : g_id
      if (WB_BYPASS) begin : g_byp
         logic unused_taken;
         fwd_single #(.XLEN(XLEN), .REG_BITS(REG_BITS)) u_rd (
            .reader_idx (rd_idx[j]),
            .base_val   (rd_rf[j]),
            .writer_idx (mwb_rd),
            .writer_en  (mwb_wen),
            .writer_val (mwb_result),
            .taken      (unused_taken),
            .out_val    (rd_out[j])
         );
      end else begin : g_pass
         // Register file is write-first; pass the read through
         logic [REG_BITS-1:0] unused_idx;
         assign unused_idx = rd_idx[j];
         assign rd_out[j]  = rd_rf[j];
      end
   end

   assign id_op1 = rd_out[0];
   assign id_op2 = rd_out[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int XLEN      = 32,
   parameter int REG_BITS  = 5,
   parameter bit WB_BYPASS = 1'b1
) (
   input logic [REG_BITS-1:0] ex_rs1,
   input logic [REG_BITS-1:0] ex_rs2,
   input logic [XLEN-1:0]     ex_rf1,
   input logic [XLEN-1:0]     ex_rf2,
   input logic [REG_BITS-1:0] exm_rd,
   input logic                exm_wen,
   input logic [XLEN-1:0]     exm_result,
   input logic [REG_BITS-1:0] mwb_rd,
   input logic                mwb_wen,
   input logic [XLEN-1:0]     mwb_result,
   input logic [REG_BITS-1:0] mem_st_rs,
   input logic [XLEN-1:0]     mem_st_val,
   input logic [REG_BITS-1:0] id_rs1,
   input logic [XLEN-1:0]     id_rf1,
   input logic [XLEN-1:0]     alu_a,
   input logic [XLEN-1:0]     alu_b,
   input logic [1:0]          sel_a,
   input logic [1:0]          sel_b,
   input logic [XLEN-1:0]     st_data,
   input logic                st_fwd,
   input logic [XLEN-1:0]     id_op1
);
   localparam logic [REG_BITS-1:0] R0 = '0;

   always_comb begin
      // R1 R3
      exm_a_chk: assert (!(exm_wen && exm_rd == ex_rs1 && ex_rs1 != R0)
                         || (sel_a == 2'b10 && alu_a == exm_result))
         else $error("operand A missed execute/memory result");
      // R2
      mwb_a_chk: assert (!(mwb_wen && mwb_rd == ex_rs1 && ex_rs1 != R0
                           && !(exm_wen && exm_rd == ex_rs1))
                         || (sel_a == 2'b01 && alu_a == mwb_result))
         else $error("operand A missed writeback result");
      // R5
      zero_src_chk: assert (ex_rs2 != R0 || (sel_b == 2'b00 && alu_b == ex_rf2))
         else $error("register 0 was forwarded");
      // R6 R4
      no_writer_chk: assert (exm_wen || mwb_wen
                             || (sel_a == 2'b00 && alu_a == ex_rf1))
         else $error("forwarded with both write enables low");
      // R9
      sel_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11)
         else $error("illegal select code");
      // R7
      store_chk: assert (st_fwd ? (st_data == mwb_result && mwb_wen && mwb_rd == mem_st_rs)
                                : (st_data == mem_st_val))
         else $error("store data path wrong");
      // R8
      id_byp_chk: assert (!WB_BYPASS || !(mwb_wen && mwb_rd == id_rs1 && id_rs1 != R0)
                          || id_op1 == mwb_result)
         else $error("decode read missed writeback value");
   end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .REG_BITS(REG_BITS), .WB_BYPASS(WB_BYPASS)) chk (
   .ex_rs1     (ex_rs1),
   .ex_rs2     (ex_rs2),
   .ex_rf1     (ex_rf1),
   .ex_rf2     (ex_rf2),
   .exm_rd     (exm_rd),
   .exm_wen    (exm_wen),
   .exm_result (exm_result),
   .mwb_rd     (mwb_rd),
   .mwb_wen    (mwb_wen),
   .mwb_result (mwb_result),
   .mem_st_rs  (mem_st_rs),
   .mem_st_val (mem_st_val),
   .id_rs1     (id_rs1),
   .id_rf1     (id_rf1),
   .alu_a      (alu_a),
   .alu_b      (alu_b),
   .sel_a      (sel_a),
   .sel_b      (sel_b),
   .st_data    (st_data),
   .st_fwd     (st_fwd),
   .id_op1     (id_op1)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
   localparam int XL = 32;
   localparam int RB = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [RB-1:0] ex_rs1, ex_rs2, exm_rd, mwb_rd, mem_st_rs, id_rs1, id_rs2;
   logic [XL-1:0] ex_rf1, ex_rf2, exm_result, mwb_result, mem_st_val, id_rf1, id_rf2;
   logic          exm_wen, mwb_wen;
   logic [XL-1:0] alu_a, alu_b, st_data, id_op1, id_op2;
   logic [1:0]    sel_a, sel_b;
   logic          st_fwd;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   fwd_unit #(.XLEN(XL), .REG_BITS(RB), .WB_BYPASS(1'b1)) uut (
      .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rf1(ex_rf1), .ex_rf2(ex_rf2),
      .exm_rd(exm_rd), .exm_wen(exm_wen), .exm_result(exm_result),
      .mwb_rd(mwb_rd), .mwb_wen(mwb_wen), .mwb_result(mwb_result),
      .mem_st_rs(mem_st_rs), .mem_st_val(mem_st_val),
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rf1(id_rf1), .id_rf2(id_rf2),
      .alu_a(alu_a), .alu_b(alu_b), .sel_a(sel_a), .sel_b(sel_b),
      .st_data(st_data), .st_fwd(st_fwd), .id_op1(id_op1), .id_op2(id_op2)
   );

   // Expected select for one source (00 file, 01 writeback, 10 execute/memory)
   function automatic logic [1:0] want_sel(logic [RB-1:0] src);
      if (src == '0) return 2'b00;
      if (exm_wen && exm_rd == src) return 2'b10;
      if (mwb_wen && mwb_rd == src) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [XL-1:0] want_val(logic [1:0] s, logic [XL-1:0] rf);
      case (s)
         2'b10:   return exm_result;
         2'b01:   return mwb_result;
         default: return rf;
      endcase
   endfunction

   function automatic logic wb_hits(logic [RB-1:0] src);
      return mwb_wen && mwb_rd == src && src != '0;
   endfunction

   task automatic check(string req, logic [XL-1:0] act, logic [XL-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      logic [1:0] sa, sb;
      sa = want_sel(ex_rs1);
      sb = want_sel(ex_rs2);
      check({tag, " R1/R2/R3/R4 sel_a"}, XL'(sel_a), XL'(sa));
      check({tag, " R9 sel_b"}, XL'(sel_b), XL'(sb));
      check({tag, " R1/R2/R4 alu_a"}, alu_a, want_val(sa, ex_rf1));
      check({tag, " R9 alu_b"}, alu_b, want_val(sb, ex_rf2));
      check({tag, " R7 st_fwd"}, XL'(st_fwd), XL'(wb_hits(mem_st_rs)));
      check({tag, " R7 st_data"}, st_data, wb_hits(mem_st_rs) ? mwb_result : mem_st_val);
      check({tag, " R8 id_op1"}, id_op1, wb_hits(id_rs1) ? mwb_result : id_rf1);
      check({tag, " R8 id_op2"}, id_op2, wb_hits(id_rs2) ? mwb_result : id_rf2);
   endtask

   task automatic idle();
      ex_rs1 = '0; ex_rs2 = '0; ex_rf1 = 32'h1111_0001; ex_rf2 = 32'h1111_0002;
      exm_rd = '0; exm_wen = 1'b0; exm_result = 32'hE0E0_0000;
      mwb_rd = '0; mwb_wen = 1'b0; mwb_result = 32'hB0B0_0000;
      mem_st_rs = '0; mem_st_val = 32'h5757_0000;
      id_rs1 = '0; id_rs2 = '0; id_rf1 = 32'hD1D1_0001; id_rf2 = 32'hD1D1_0002;
   endtask

   initial begin
      #50000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd365));
      idle();
      @(negedge clk); #1;
      // R4 idle state: everything from the file
      check("R4 idle sel_a", XL'(sel_a), 0);
      check("R4 idle alu_a", alu_a, 32'h1111_0001);
      check("R7 idle st_data", st_data, 32'h5757_0000);

      // Chain: producer writes r1 = 0x55
      @(negedge clk); idle();
      ex_rs1 = 5'd1; ex_rs2 = 5'd5; exm_rd = 5'd1; exm_wen = 1'b1; exm_result = 32'h55;
      #1;
      check("R1 first reader sel_a", XL'(sel_a), 2);
      check("R1 first reader alu_a", alu_a, 32'h55);
      check("R9 other operand from file", alu_b, 32'h1111_0002);

      @(negedge clk); idle();
      ex_rs2 = 5'd1; mwb_rd = 5'd1; mwb_wen = 1'b1; mwb_result = 32'h55;
      id_rs1 = 5'd1;
      #1;
      check("R2 second reader sel_b", XL'(sel_b), 1);
      check("R2 second reader alu_b", alu_b, 32'h55);
      check("R8 third reader id_op1", id_op1, 32'h55);

      // Producer r3 in writeback, store of r3 in memory stage
      @(negedge clk); idle();
      mwb_rd = 5'd3; mwb_wen = 1'b1; mwb_result = 32'hA5A5; mem_st_rs = 5'd3;
      #1;
      check("R7 store fwd flag", XL'(st_fwd), 1);
      check("R7 store data", st_data, 32'hA5A5);

      // Both producers hit the same register
      @(negedge clk); idle();
      ex_rs1 = 5'd7; exm_rd = 5'd7; exm_wen = 1'b1; mwb_rd = 5'd7; mwb_wen = 1'b1;
      #1;
      check("R3 priority sel_a", XL'(sel_a), 2);
      check("R3 priority alu_a", alu_a, 32'hE0E0_0000);

      // Matching numbers with enables low
      @(negedge clk); idle();
      ex_rs1 = 5'd9; exm_rd = 5'd9; mwb_rd = 5'd9; mem_st_rs = 5'd9; id_rs2 = 5'd9;
      #1;
      check("R6 no enable sel_a", XL'(sel_a), 0);
      check("R6 no enable st_fwd", XL'(st_fwd), 0);
      check("R6 no enable id_op2", id_op2, 32'hD1D1_0002);

      // Register 0 targets
      @(negedge clk); idle();
      exm_wen = 1'b1; mwb_wen = 1'b1;
      #1;
      check("R5 zero sel_a", XL'(sel_a), 0);
      check("R5 zero alu_b", alu_b, 32'h1111_0002);
      check("R5 zero st_fwd", XL'(st_fwd), 0);
      check("R5 zero id_op1", id_op1, 32'hD1D1_0001);

      // Random vectors with a small register range
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         ex_rs1 = RB'($urandom_range(0, 3)); ex_rs2 = RB'($urandom_range(0, 3));
         exm_rd = RB'($urandom_range(0, 3)); mwb_rd = RB'($urandom_range(0, 3));
         mem_st_rs = RB'($urandom_range(0, 3));
         id_rs1 = RB'($urandom_range(0, 3)); id_rs2 = RB'($urandom_range(0, 3));
         exm_wen = 1'($urandom); mwb_wen = 1'($urandom);
         ex_rf1 = $urandom; ex_rf2 = $urandom; exm_result = $urandom; mwb_result = $urandom;
         mem_st_val = $urandom; id_rf1 = $urandom; id_rf2 = $urandom;
         #1;
         check_all("rand");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule